// File: doc/BRIEF.md
# Handshaked Parallel Control-Store Loader

This block takes a program image from a byte-wide parallel port and turns it into write operations on a control store. The sender presents one byte at a time on a 16-bit input word. The top bit of that word is a send strobe and the low eight bits carry the data. The block filters each byte by sampling it repeatedly. It acknowledges the byte by changing a 16-bit control word that it drives back to the sender, and it keeps that acknowledge up until the sender lets go of its strobe.

Bytes are grouped into records of seven. The first two bytes form an address, high byte first. The next four bytes form two 16-bit data words. The seventh byte supplies the 4-bit third part of a 36-bit control-store word. A finished record produces two write operations on consecutive cycles. When the address of a record has its top bit set, the record is a jump command and no write takes place. The block instead emits the low 12 address bits together with a one-cycle start pulse, and from then on it ignores the port.

Top module: `cs_loader`

## Requirements
- R1: While reset is asserted and directly after it, `portCtrl` equals octal 400 (0x0100, acknowledge bit 10 low), `csWrEn` is 0 and `startPulse` is 0.
- R2: A byte is taken only when bit 15 of `portIn` is 1 and the whole 16-bit `portIn` value is identical on three consecutive rising edges. If the second or third sample differs, the block goes back to waiting for the strobe, and the next strobe seen starts a new byte.
- R3: From the cycle after a byte is taken, `portCtrl` equals octal 2400 (0x0500). It keeps that value until the first edge at which `portIn` bit 15 is 0, and after that edge it returns to octal 400.
- R4: A record is seven taken bytes in a fixed order: address high, address low, word-0 high, word-0 low, word-1 high, word-1 low, and last byte. Every record whose address bit 15 is 0 produces exactly one pair of writes.
- R5: In the cycle after the seventh byte is taken, `csWrEn`=1 and `csWrHalf`=0, with `csWrData` = word 0. In the cycle after that, `csWrEn`=1 and `csWrHalf`=1, with `csWrData` = word 1 and `csWrExtra`=0. In both cycles `csAddr` = address bits 11:0. `csWrEn` is 0 in all other cycles.
- R6: When the second byte of a record is taken and the address has bit 15 set, `startPulse` is 1 for exactly the next cycle. In that cycle `startAddr` = address bits 11:0, so bits 15:12 are dropped. No write is issued for that record.
- R7: After the start pulse, once the acknowledge of the jump byte is released, the port is ignored: `portCtrl` stays at octal 400 and `csWrEn` stays 0 whatever arrives on `portIn`.
- R8: In the first write cycle, `csWrExtra` equals bits 3:0 of the seventh byte. Bits 7:4 of that byte are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portIn | input | 16 | Parallel port word; bit 15 is the send strobe and bits 7:0 are the data |
| portCtrl | output | 16 | Control word to the sender: octal 400 in receive mode, octal 2400 while acknowledging |
| csWrEn | output | 1 | Control-store write strobe |
| csWrHalf | output | 1 | 0: write word 0 and the extra bits; 1: write word 1 |
| csAddr | output | 12 | Control-store write address |
| csWrData | output | 16 | Write data, word 0 or word 1 |
| csWrExtra | output | 4 | Bits 35:32 of the stored word; valid when csWrHalf is 0 |
| startPulse | output | 1 | One-cycle pulse that starts execution |
| startAddr | output | 12 | Start address, valid with startPulse |

## Verification
The receiver keeps running while a record is being written. With a sender that holds each strobe for exactly three cycles and drops it for one, the first write cycle lands in the same cycle as the rising acknowledge. The second write cycle then lands on the edge where the next strobe is first sampled. The bench drives a full record followed directly by a jump record with this tightest timing. It also sends records with slack timing, with sample disagreements and with a strobe pulse that is too short. A behavioural reference model built from queues predicts the acknowledge word, the write fields and the start pulse for every cycle. The bench compares all of them on every falling edge, so a write that stalls the receiver, or a receiver that corrupts a pending write, shows up as a mismatch in that cycle.

// File: rtl/cs_loader_pkg.sv
package cs_loader_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic shiftIn;   // shift the taken byte into the accumulator
    logic loadAddr;  // capture the assembled address
    logic loadW0;    // capture the assembled word 0
    logic loadW1;    // capture the assembled word 1
    logic loadExt;   // capture the low bits of the last byte
  } dpStrobe_t;

  typedef enum logic [1:0] {
    RX_WAIT = 2'd0,
    RX_CHK1 = 2'd1,
    RX_CHK2 = 2'd2,
    RX_ACK  = 2'd3
  } rxState_t;

endpackage

// File: rtl/cs_loader_dp.sv
module cs_loader_dp
  import cs_loader_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int EXT_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteIn,
  input  dpStrobe_t         stb,
  input  logic              wrHalf,
  output logic              jumpFlag,
  output logic [ADDR_W-1:0] csAddr,
  output logic [ADDR_W-1:0] startAddr,
  output logic [WORD_W-1:0] csWrData,
  output logic [EXT_W-1:0]  csWrExtra
);

  localparam int KEEP_W = WORD_W - BYTE_W;

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] accNext;
  logic [WORD_W-1:0] addrReg;
  logic [WORD_W-1:0] word0;
  logic [WORD_W-1:0] word1;
  logic [EXT_W-1:0]  extReg;

  // Most significant byte first: older bytes move up
  assign accNext  = {acc[KEEP_W-1:0], byteIn};
  assign jumpFlag = accNext[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      addrReg <= '0;
      word0   <= '0;
      word1   <= '0;
      extReg  <= '0;
    end else begin
      if (stb.shiftIn)  acc     <= accNext;
      if (stb.loadAddr) addrReg <= accNext;
      if (stb.loadW0)   word0   <= accNext;
      if (stb.loadW1)   word1   <= accNext;
      if (stb.loadExt)  extReg  <= byteIn[EXT_W-1:0];
    end
  end

  // Upper address bits are dropped for both the write and the jump target
  assign csAddr    = addrReg[ADDR_W-1:0];
  assign startAddr = addrReg[ADDR_W-1:0];
  assign csWrData  = wrHalf ? word1 : word0;
  assign csWrExtra = wrHalf ? '0 : extReg;

endmodule

// File: rtl/cs_loader_ctrl.sv
module cs_loader_ctrl
  import cs_loader_pkg::*;
#(
  parameter int              PORT_W   = 16,
  parameter int              WORD_W   = 16,
  parameter int              BYTE_W   = 8,
  parameter logic [PORT_W-1:0] CTRL_RX  = 16'o400,
  parameter logic [PORT_W-1:0] CTRL_ACK = 16'o2400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] portIn,
  input  logic              jumpFlag,
  output logic [PORT_W-1:0] portCtrl,
  output dpStrobe_t         stb,
  output logic              wrHalf,
  output logic              csWrEn,
  output logic              startPulse
);

  localparam int STB_BIT     = PORT_W - 1;
  localparam int FIELD_BYTES = WORD_W / BYTE_W;
  localparam int LAST_IDX    = 3 * FIELD_BYTES;
  localparam int IDX_W       = $clog2(LAST_IDX + 1);
  localparam logic [IDX_W-1:0] ADDR_IDX = IDX_W'(FIELD_BYTES - 1);
  localparam logic [IDX_W-1:0] W0_IDX   = IDX_W'(2 * FIELD_BYTES - 1);
  localparam logic [IDX_W-1:0] W1_IDX   = IDX_W'(3 * FIELD_BYTES - 1);
  localparam logic [IDX_W-1:0] EXT_IDX  = IDX_W'(LAST_IDX);

  rxState_t          rxState;
  logic [PORT_W-1:0] heldWord;
  logic              halted;
  logic [IDX_W-1:0]  byteIdx;
  logic [1:0]        wrPhase;
  logic              byteTake;
  logic              addrDone;
  logic              jumpNow;
  logic              lastByte;

  assign byteTake = (rxState == RX_CHK2) && (portIn == heldWord);
  assign addrDone = byteTake && (byteIdx == ADDR_IDX);
  assign jumpNow  = addrDone && jumpFlag;
  assign lastByte = byteTake && (byteIdx == EXT_IDX);

  // Receiver: strobe detect, two confirming samples, acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= RX_WAIT;
      heldWord <= '0;
    end else begin
      unique case (rxState)
        RX_WAIT: if (!halted && portIn[STB_BIT]) begin
          heldWord <= portIn;
          rxState  <= RX_CHK1;
        end
        RX_CHK1: rxState <= (portIn == heldWord) ? RX_CHK2 : RX_WAIT;
        RX_CHK2: rxState <= (portIn == heldWord) ? RX_ACK : RX_WAIT;
        RX_ACK:  if (!portIn[STB_BIT]) rxState <= RX_WAIT;
        default: rxState <= RX_WAIT;
      endcase
    end
  end

  // Record sequencer and write issue; runs beside the receiver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx    <= '0;
      halted     <= 1'b0;
      startPulse <= 1'b0;
      wrPhase    <= 2'd0;
    end else begin
      if (jumpNow || lastByte) byteIdx <= '0;
      else if (byteTake)       byteIdx <= byteIdx + 1'b1;
      halted     <= halted | jumpNow;
      startPulse <= jumpNow;
      if (lastByte)            wrPhase <= 2'd1;
      else if (wrPhase == 2'd1) wrPhase <= 2'd2;
      else                     wrPhase <= 2'd0;
    end
  end

  always_comb begin
    stb          = '0;
    stb.shiftIn  = byteTake;
    stb.loadAddr = addrDone;
    stb.loadW0   = byteTake && (byteIdx == W0_IDX);
    stb.loadW1   = byteTake && (byteIdx == W1_IDX);
    stb.loadExt  = lastByte;
  end

  assign portCtrl = (rxState == RX_ACK) ? CTRL_ACK : CTRL_RX;
  assign csWrEn   = (wrPhase != 2'd0);
  assign wrHalf   = (wrPhase == 2'd2);

  // R2: a byte is taken only after three identical strobed samples
  a_r2_take_needs_agreement: assert property (@(posedge clk) disable iff (!rstN)
    byteTake |-> (portIn[STB_BIT] && portIn == $past(portIn) && portIn == $past(portIn, 2)));

  // R3: acknowledge held while the strobe stays high
  a_r3_ack_held: assert property (@(posedge clk) disable iff (!rstN)
    (portCtrl == CTRL_ACK && portIn[STB_BIT]) |=> (portCtrl == CTRL_ACK));

  // R3: acknowledge released after the strobe is seen low
  a_r3_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    (portCtrl == CTRL_ACK && !portIn[STB_BIT]) |=> (portCtrl == CTRL_RX));

  // R5: the word-0 write is always followed by the word-1 write
  a_r5_write_pair: assert property (@(posedge clk) disable iff (!rstN)
    (csWrEn && !wrHalf) |=> (csWrEn && wrHalf));

  // R6: the start pulse lasts one cycle
  a_r6_single_start: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R7: after start nothing is written and nothing new is taken
  a_r7_silent_after_start: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!csWrEn && !byteTake));

endmodule

// File: rtl/cs_loader.sv
module cs_loader
  import cs_loader_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int EXT_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] portIn,
  output logic [PORT_W-1:0] portCtrl,
  output logic              csWrEn,
  output logic              csWrHalf,
  output logic [ADDR_W-1:0] csAddr,
  output logic [WORD_W-1:0] csWrData,
  output logic [EXT_W-1:0]  csWrExtra,
  output logic              startPulse,
  output logic [ADDR_W-1:0] startAddr
);

  dpStrobe_t stb;
  logic      jumpFlag;

  cs_loader_ctrl #(
    .PORT_W (PORT_W),
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .portIn     (portIn),
    .jumpFlag   (jumpFlag),
    .portCtrl   (portCtrl),
    .stb        (stb),
    .wrHalf     (csWrHalf),
    .csWrEn     (csWrEn),
    .startPulse (startPulse)
  );

  cs_loader_dp #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W),
    .EXT_W  (EXT_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .byteIn    (portIn[BYTE_W-1:0]),
    .stb       (stb),
    .wrHalf    (csWrHalf),
    .jumpFlag  (jumpFlag),
    .csAddr    (csAddr),
    .startAddr (startAddr),
    .csWrData  (csWrData),
    .csWrExtra (csWrExtra)
  );

endmodule

// File: tb/cs_loader_test.sv
`timescale 1ns/1ps
module cs_loader_test;

  typedef struct packed {
    logic        half;
    logic [11:0] a;
    logic [15:0] d;
    logic [3:0]  e;
  } wr_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] portIn = '0;
  logic [15:0] portCtrl;
  logic        csWrEn, csWrHalf, startPulse;
  logic [11:0] csAddr, startAddr;
  logic [15:0] csWrData;
  logic [3:0]  csWrExtra;

  int compared = 0;
  int mismatched = 0;
  int obsWrites = 0;
  int obsStarts = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cs_loader uut (
    .clk(clk), .rstN(rstN), .portIn(portIn), .portCtrl(portCtrl),
    .csWrEn(csWrEn), .csWrHalf(csWrHalf), .csAddr(csAddr),
    .csWrData(csWrData), .csWrExtra(csWrExtra),
    .startPulse(startPulse), .startAddr(startAddr)
  );

  // Reference model state
  int          mPhase = 0;   // 0 idle, 1 one sample, 2 two samples, 3 acknowledging
  logic [15:0] mHeld = '0;
  bit          mDead = 1'b0;
  logic [7:0]  rec[$];
  wr_t         wq[$];
  logic [15:0] eCtrl = 16'o400;
  bit          eEn = 1'b0;
  wr_t         eWr = '0;
  bit          eStart = 1'b0;
  logic [11:0] eStartAddr = '0;

  always @(posedge clk) begin : model
    bit got;
    logic [15:0] a;
    got = 1'b0;
    if (!rstN) begin
      mPhase = 0; mDead = 1'b0; rec.delete(); wq.delete();
      eEn = 1'b0; eStart = 1'b0; eCtrl = 16'o400;
    end else begin
      eStart = 1'b0;
      case (mPhase)
        0: if (!mDead && portIn[15]) begin mHeld = portIn; mPhase = 1; end
        1: mPhase = (portIn == mHeld) ? 2 : 0;
        2: if (portIn == mHeld) begin got = 1'b1; mPhase = 3; end else mPhase = 0;
        default: if (!portIn[15]) mPhase = 0;
      endcase
      if (got) begin
        rec.push_back(mHeld[7:0]);
        a = {rec[0], (rec.size() > 1) ? rec[1] : 8'h00};
        if (rec.size() == 2 && a[15]) begin
          eStart = 1'b1; eStartAddr = a[11:0]; mDead = 1'b1; rec.delete();
        end else if (rec.size() == 7) begin
          wq.push_back('{half: 1'b0, a: a[11:0], d: {rec[2], rec[3]}, e: rec[6][3:0]});
          wq.push_back('{half: 1'b1, a: a[11:0], d: {rec[4], rec[5]}, e: 4'h0});
          rec.delete();
        end
      end
      if (wq.size() > 0) begin eWr = wq.pop_front(); eEn = 1'b1; end
      else eEn = 1'b0;
      eCtrl = (mPhase == 3) ? 16'o2400 : 16'o400;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    string tagC;
    if (!finished) begin
      tagC = !rstN ? "R1" : (mDead && mPhase == 0) ? "R7" : "R3";
      check(portCtrl === eCtrl, tagC, "portCtrl", 32'(portCtrl), 32'(eCtrl));
      check(csWrEn === eEn, mDead ? "R7" : "R5", "csWrEn", 32'(csWrEn), 32'(eEn));
      check(startPulse === eStart, !rstN ? "R1" : "R6", "startPulse", 32'(startPulse), 32'(eStart));
      if (eEn && csWrEn) begin
        obsWrites++;
        check(csWrHalf === eWr.half, "R5", "csWrHalf", 32'(csWrHalf), 32'(eWr.half));
        check(csAddr === eWr.a, "R5", "csAddr", 32'(csAddr), 32'(eWr.a));
        check(csWrData === eWr.d, "R4", "csWrData", 32'(csWrData), 32'(eWr.d));
        check(csWrExtra === eWr.e, "R8", "csWrExtra", 32'(csWrExtra), 32'(eWr.e));
      end
      if (eStart && startPulse) begin
        obsStarts++;
        check(startAddr === eStartAddr, "R6", "startAddr", 32'(startAddr), 32'(eStartAddr));
      end
    end
  end

  task automatic sendRaw(input logic [15:0] v, input int cycles);
    portIn = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input int hi, input int lo);
    sendRaw({1'b1, 7'd0, b}, hi);
    sendRaw(16'h0000, lo);
  endtask

  task automatic sendRec(input logic [15:0] ad, input logic [15:0] w0,
                         input logic [15:0] w1, input logic [7:0] last,
                         input int hi, input int lo);
    sendByte(ad[15:8], hi, lo); sendByte(ad[7:0], hi, lo);
    sendByte(w0[15:8], hi, lo); sendByte(w0[7:0], hi, lo);
    sendByte(w1[15:8], hi, lo); sendByte(w1[7:0], hi, lo);
    sendByte(last, hi, lo);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    // R1: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 R8: relaxed timing, upper bits of last byte discarded
    sendRec(16'h0123, 16'hABCD, 16'h1357, 8'hF6, 4, 2);
    repeat (3) @(negedge clk);

    // R2: disagreement at the second sample, then at the third, then a short strobe
    sendRaw({1'b1, 7'd0, 8'h02}, 1);
    sendRaw({1'b1, 7'd0, 8'h03}, 4);   // byte 0x03 taken
    sendRaw(16'h0000, 2);
    sendRaw({1'b1, 7'd0, 8'h99}, 2);
    sendRaw({1'b1, 7'd0, 8'h10}, 4);   // byte 0x10 taken
    sendRaw(16'h0000, 2);
    sendRaw({1'b1, 7'd0, 8'h55}, 2);   // too short: ignored
    sendRaw(16'h0000, 3);
    sendByte(8'h00, 5, 3); sendByte(8'hFF, 3, 1);
    sendByte(8'h80, 4, 2); sendByte(8'h01, 3, 2);
    sendByte(8'h09, 6, 1);
    repeat (2) @(negedge clk);

    // R5 R3: tightest timing, next record follows at once
    sendRec(16'h7FFF, 16'h0F0F, 16'hF0F0, 8'h3A, 3, 1);

    // R6: jump record, upper address bits cleared
    sendByte(8'h9A, 3, 1);
    sendByte(8'hBC, 3, 1);

    // R7: further traffic is ignored
    sendRec(16'h0042, 16'h1111, 16'h2222, 8'h05, 4, 2);
    sendRaw({1'b1, 7'd0, 8'h77}, 8);
    sendRaw(16'h0000, 4);

    // R4: three ordinary records gave three write pairs
    check(obsWrites == 6, "R4", "write count", 32'(obsWrites), 32'd6);
    // R6: exactly one start
    check(obsStarts == 1, "R6", "start count", 32'(obsStarts), 32'd1);
    finish_run();
  end

endmodule